// File: doc/BRIEF.md
# Timed Panel Power Sequencer

This block powers up a flat panel by stepping through a fixed chain of stages, raising one enable line per stage and holding off the next stage until a programmable millisecond delay has passed. A free-running microsecond counter, advanced by a one-cycle tick input, is the timebase. Each millisecond delay is scaled by 1000 into that counter's units and stored as an absolute deadline. The deadline is compared with wrap-safe signed subtraction, so the counter may roll over in the middle of a wait.

A start pulse runs the first stage at once. From then on the block advances in one of two ways, chosen by a mode input. In run-through mode it steps by itself whenever the deadline has passed, until it reaches the final stage. In polled mode it steps only when a poll strobe arrives after the deadline; a poll that comes early does nothing. Each of the four rails can be marked absent. The stage for an absent rail still runs and still starts its delay, but it leaves that output low. The PWM stage gives a one-cycle load strobe and a run level, and presents fixed duty, frequency and divider settings for an external waveform generator.

Top module: `panel_pwrseq`

## Requirements
- R1: After a cycle with rst_n low, stage_o is 0, done_o is 0, and every enable, pwm_run_o, pwm_load_o and pwm_duty_o are 0.
- R2: stage_o is encoded as 0 start, 1 panel supply, 2 link enable, 3 backlight supply, 4 PWM, 5 backlight enable, 6 done. It only ever moves up by exactly one per executed stage.
- R3: In stage 0, a start_i pulse runs the start stage on that clock edge with no wait, so stage_o reads 1 in the next cycle.
- R4: After stage k (0 to 3) runs, stage k+1 runs no sooner than delay_ms_i[8k+7:8k] × 1000 counted usec_tick_i cycles later. With the tick high on every cycle and run-through mode, it runs exactly that many edges later, or on the next edge when the field is 0.
- R5: The PWM stage and the backlight-enable stage start no delay, so the next stage runs on the next edge.
- R6: present_i bit 0 enables the panel supply, bit 1 the link, bit 2 the backlight supply and bit 3 the backlight enable. When a bit is 0, that output stays low, but its stage still advances and its delay still applies.
- R7: With wait_mode_i = 0, a stage runs only on a cycle with poll_i high after its deadline. A poll before the deadline, or a passed deadline with no poll, leaves the stage unchanged.
- R8: With wait_mode_i = 1, the sequence advances to stage 6 without any poll.
- R9: When the PWM stage runs, pwm_load_o is high for exactly one cycle and pwm_run_o stays high from then on. While pwm_run_o is high, pwm_duty_o = 0xDF, pwm_hz_o = 32768 and pwm_div_o = 1; pwm_duty_o is 0 otherwise.
- R10: A start_i pulse in stages 1 to 6 has no effect.
- R11: Once an enable output is high, it stays high until reset.
- R12: The deadline compare gives correct timing when the microsecond counter wraps during a wait.
- R13: done_o is high exactly when stage_o is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, honoured only in stage 0 |
| poll_i | input | 1 | Advance request in polled mode |
| wait_mode_i | input | 1 | 1 = run through, 0 = polled |
| usec_tick_i | input | 1 | One-cycle microsecond tick |
| delay_ms_i | input | 32 | Four 8-bit millisecond delays, field k after stage k |
| present_i | input | 4 | Rail presence flags |
| panel_vdd_o | output | 1 | Panel supply enable |
| lvds_en_o | output | 1 | Panel link enable |
| bl_vdd_o | output | 1 | Backlight supply enable |
| pwm_run_o | output | 1 | Backlight PWM running |
| pwm_load_o | output | 1 | One-cycle PWM settings load strobe |
| pwm_duty_o | output | 8 | PWM duty out of 256 |
| pwm_hz_o | output | 16 | PWM frequency in Hz |
| pwm_div_o | output | 4 | PWM clock divider |
| bl_en_o | output | 1 | Backlight enable |
| stage_o | output | 3 | Next stage to run |
| done_o | output | 1 | Sequence complete |

## Verification
A start pulse can coincide with a stage advance, and a poll can land on exactly the cycle its deadline expires. The bench pulses start in the middle of delays and at the final stage, and drives random start, poll and tick patterns together. A cycle-level model built from the requirements checks that only the due stage advances and that start is ignored. Directed runs measure the edge distance between stage changes, with the counter starting 512 microseconds before wrap, so that the first wait crosses zero.

// File: rtl/psq_pkg.sv
// Shared stage encoding for the panel power sequencer.
// Assumes stage codes are consecutive; the stage register advances by +1.
package psq_pkg;
    typedef enum logic [2:0] {
        STG_START = 3'd0,
        STG_PANEL = 3'd1,
        STG_LINK  = 3'd2,
        STG_BLSUP = 3'd3,
        STG_PWM   = 3'd4,
        STG_BLON  = 3'd5,
        STG_DONE  = 3'd6
    } psq_stage_e;

    localparam int N_TIMED = 4;   // stages 0..N_TIMED-1 start a delay
    localparam int N_RAILS = 4;   // optional enable rails
endpackage

// File: rtl/psq_deadline.sv
// Microsecond timebase and deadline tracker.
// Keeps a free-running counter advanced by tick_i. On arm_i it stores an
// absolute deadline of now + delay*US_PER_MS, or now when no delay applies.
// due_o uses signed distance, so counter wrap is harmless as long as the
// delays stay below half the counter range.
module psq_deadline #(
    parameter int CNT_W = 32,
    parameter int DLY_W = 8,
    parameter int US_PER_MS = 1000,
    parameter logic [CNT_W-1:0] TIME_START = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic             arm_timed_i,
    input  logic [DLY_W-1:0] delay_ms_i,
    output logic             due_o
);
    localparam logic [CNT_W-1:0] SCALE = CNT_W'(US_PER_MS);

    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] limit_q;
    logic [CNT_W-1:0] span;
    logic [CNT_W-1:0] remain;

    // Scale the millisecond delay into microsecond units.
    always_comb span = {{(CNT_W-DLY_W){1'b0}}, delay_ms_i} * SCALE;

    // Free-running microsecond counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      now_q <= TIME_START;
        else if (tick_i) now_q <= now_q + 1'b1;
    end

    // Capture the deadline when a stage runs.
    always_ff @(posedge clk) begin
        if (!rst_n)     limit_q <= TIME_START;
        else if (arm_i) limit_q <= arm_timed_i ? now_q + span : now_q;
    end

    // Due when the signed distance to the deadline is zero or negative.
    always_comb begin
        remain = limit_q - now_q;
        due_o  = (remain == '0) || remain[CNT_W-1];
    end

    // R4
    armed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && arm_timed_i && delay_ms_i != '0) |=> !due_o);
endmodule

// File: rtl/psq_stage_ctl.sv
// Stage register and advance decision.
// Stage 0 runs on start_i with no wait. Stages 1..5 run when the deadline is
// due and either run-through mode is set or a poll arrives. Stage 6 is final.
module psq_stage_ctl
    import psq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       poll_i,
    input  logic       wait_mode_i,
    input  logic       due_i,
    output psq_stage_e stage_o,
    output logic       fire_o,
    output logic       arm_timed_o
);
    psq_stage_e stage_q;

    // Decide whether the current stage runs on this edge.
    always_comb begin
        if (stage_q == STG_START)     fire_o = start_i;
        else if (stage_q == STG_DONE) fire_o = 1'b0;
        else                          fire_o = due_i && (wait_mode_i || poll_i);
    end

    // Only the first N_TIMED stages start a delay.
    always_comb arm_timed_o = (int'(stage_q) < N_TIMED);

    // Advance the stage register by one on each run.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= STG_START;
        else if (fire_o) stage_q <= psq_stage_e'(stage_q + 3'd1);
    end

    assign stage_o = stage_q;

    // R2
    stage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_q != $past(stage_q)) |-> (3'(stage_q) == 3'($past(stage_q)) + 3'd1));
endmodule

// File: rtl/psq_drivers.sv
// Output drivers: sticky rail enables, gated by presence flags, and the PWM
// load strobe and run level. Rail i is raised by its own stage code.
module psq_drivers
    import psq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  psq_stage_e         fire_stage_i,
    input  logic [N_RAILS-1:0] present_i,
    output logic [N_RAILS-1:0] rails_o,
    output logic               pwm_run_o,
    output logic               pwm_load_o
);
    function automatic psq_stage_e rail_stage(input int idx);
        case (idx)
            0:       return STG_PANEL;
            1:       return STG_LINK;
            2:       return STG_BLSUP;
            default: return STG_BLON;
        endcase
    endfunction

    logic [N_RAILS-1:0] rails_q;

    for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
        // Raise rail i on its stage when present; hold until reset.
        always_ff @(posedge clk) begin
            if (!rst_n) rails_q[i] <= 1'b0;
            else if (fire_i && fire_stage_i == rail_stage(i) && present_i[i])
                rails_q[i] <= 1'b1;
        end

        // R11
        rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rails_q[i] |=> rails_q[i]);
    end

    // PWM strobe for one cycle and sticky run level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_load_o <= 1'b0;
            pwm_run_o  <= 1'b0;
        end else begin
            pwm_load_o <= fire_i && fire_stage_i == STG_PWM;
            if (fire_i && fire_stage_i == STG_PWM) pwm_run_o <= 1'b1;
        end
    end

    assign rails_o = rails_q;

    // R9
    pwm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_load_o |=> (!pwm_load_o && pwm_run_o));
endmodule

// File: rtl/panel_pwrseq.sv
// Timed panel power sequencer top.
// Links the deadline tracker, the stage controller and the output drivers.
// Assumes delay_ms_i and present_i are stable while a sequence runs.
module panel_pwrseq
    import psq_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DLY_W = 8,
    parameter int US_PER_MS = 1000,
    parameter logic [CNT_W-1:0] TIME_START = '0,
    parameter int DUTY_W = 8,
    parameter int HZ_W = 16,
    parameter int DIV_W = 4,
    parameter logic [DUTY_W-1:0] PWM_DUTY = 8'hDF,
    parameter logic [HZ_W-1:0] PWM_HZ = 16'd32768,
    parameter logic [DIV_W-1:0] PWM_DIV = 4'd1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     poll_i,
    input  logic                     wait_mode_i,
    input  logic                     usec_tick_i,
    input  logic [N_TIMED*DLY_W-1:0] delay_ms_i,
    input  logic [N_RAILS-1:0]       present_i,
    output logic                     panel_vdd_o,
    output logic                     lvds_en_o,
    output logic                     bl_vdd_o,
    output logic                     pwm_run_o,
    output logic                     pwm_load_o,
    output logic [DUTY_W-1:0]        pwm_duty_o,
    output logic [HZ_W-1:0]          pwm_hz_o,
    output logic [DIV_W-1:0]         pwm_div_o,
    output logic                     bl_en_o,
    output logic [2:0]               stage_o,
    output logic                     done_o
);
    localparam int SEL_W = $clog2(N_TIMED);

    psq_stage_e         stage;
    logic               fire;
    logic               arm_timed;
    logic               due;
    logic [SEL_W-1:0]   sel;
    logic [DLY_W-1:0]   cur_delay;
    logic [N_RAILS-1:0] rails;

    // Pick the delay field that belongs to the stage now running.
    always_comb begin
        sel       = stage[SEL_W-1:0];
        cur_delay = delay_ms_i[sel*DLY_W +: DLY_W];
    end

    psq_deadline #(
        .CNT_W(CNT_W), .DLY_W(DLY_W), .US_PER_MS(US_PER_MS), .TIME_START(TIME_START)
    ) u_deadline (
        .clk(clk), .rst_n(rst_n), .tick_i(usec_tick_i), .arm_i(fire),
        .arm_timed_i(arm_timed), .delay_ms_i(cur_delay), .due_o(due)
    );

    psq_stage_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_i(poll_i),
        .wait_mode_i(wait_mode_i), .due_i(due), .stage_o(stage),
        .fire_o(fire), .arm_timed_o(arm_timed)
    );

    psq_drivers u_drv (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .fire_stage_i(stage),
        .present_i(present_i), .rails_o(rails), .pwm_run_o(pwm_run_o),
        .pwm_load_o(pwm_load_o)
    );

    // Map rails and present the fixed PWM settings while running.
    always_comb begin
        panel_vdd_o = rails[0];
        lvds_en_o   = rails[1];
        bl_vdd_o    = rails[2];
        bl_en_o     = rails[3];
        pwm_duty_o  = pwm_run_o ? PWM_DUTY : '0;
        pwm_hz_o    = PWM_HZ;
        pwm_div_o   = PWM_DIV;
        stage_o     = 3'(stage);
        done_o      = (stage == STG_DONE);
    end

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stage != STG_START && start_i && !due) |=> $stable(stage));
endmodule

// File: tb/panel_pwrseq_test.sv
module panel_pwrseq_test;
    localparam logic [31:0] T0 = 32'hFFFF_FE00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, poll_i = 1'b0, wait_mode_i = 1'b1, usec_tick_i = 1'b1;
    logic [31:0] delay_ms_i = '0;
    logic [3:0] present_i = 4'hF;
    logic panel_vdd_o, lvds_en_o, bl_vdd_o, pwm_run_o, pwm_load_o, bl_en_o, done_o;
    logic [7:0] pwm_duty_o;
    logic [15:0] pwm_hz_o;
    logic [3:0] pwm_div_o;
    logic [2:0] stage_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    panel_pwrseq #(.TIME_START(T0)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_i(poll_i),
        .wait_mode_i(wait_mode_i), .usec_tick_i(usec_tick_i), .delay_ms_i(delay_ms_i),
        .present_i(present_i), .panel_vdd_o(panel_vdd_o), .lvds_en_o(lvds_en_o),
        .bl_vdd_o(bl_vdd_o), .pwm_run_o(pwm_run_o), .pwm_load_o(pwm_load_o),
        .pwm_duty_o(pwm_duty_o), .pwm_hz_o(pwm_hz_o), .pwm_div_o(pwm_div_o),
        .bl_en_o(bl_en_o), .stage_o(stage_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
        end
    endtask

    // Reference model built from the requirements, updated per clock edge.
    logic [31:0] m_now, m_dl;
    logic [2:0]  m_stage;
    logic [3:0]  m_rail;
    logic        m_run, m_load;

    function automatic logic ref_due(input logic [31:0] dl, input logic [31:0] now);
        logic [31:0] d = dl - now;
        return (d == 0) || d[31];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_now = T0; m_dl = T0; m_stage = 0; m_rail = 0; m_run = 0; m_load = 0;
        end else begin
            logic fire;
            if (m_stage == 0)      fire = start_i;
            else if (m_stage == 6) fire = 1'b0;
            else fire = ref_due(m_dl, m_now) && (wait_mode_i || poll_i);
            m_load = 1'b0;
            if (fire) begin
                case (m_stage)
                    3'd1: if (present_i[0]) m_rail[0] = 1'b1;
                    3'd2: if (present_i[1]) m_rail[1] = 1'b1;
                    3'd3: if (present_i[2]) m_rail[2] = 1'b1;
                    3'd4: begin m_run = 1'b1; m_load = 1'b1; end
                    3'd5: if (present_i[3]) m_rail[3] = 1'b1;
                    default: ;
                endcase
                if (m_stage < 4) m_dl = m_now + 32'(delay_ms_i[m_stage*8 +: 8]) * 32'd1000;
                else             m_dl = m_now;
                m_stage = m_stage + 3'd1;
            end
            if (usec_tick_i) m_now = m_now + 32'd1;
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 stage", 32'(stage_o), 32'(m_stage));
            check("R13 done", 32'(done_o), 32'(m_stage == 3'd6));
            check("R6/R11 rails", 32'({bl_en_o, bl_vdd_o, lvds_en_o, panel_vdd_o}), 32'(m_rail));
            check("R9 pwm run/load", 32'({pwm_run_o, pwm_load_o}), 32'({m_run, m_load}));
            check("R9 duty", 32'(pwm_duty_o), m_run ? 32'hDF : 32'h0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 0; poll_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Wait for stage_o to leave its current value; return the cycle seen.
    task automatic wait_change(output int at);
        logic [2:0] prev = stage_o;
        int n = 0;
        while (stage_o == prev && n < 30000) begin
            @(negedge clk);
            n++;
        end
        at = cyc;
    endtask

    initial begin
        int c1, c2, c3, c4, c5, c6;
        void'($urandom(32'd20240611));

        // Directed run-through sequence; the first wait crosses counter wrap.
        wait_mode_i = 1; usec_tick_i = 1; delay_ms_i = {8'd1, 8'd2, 8'd0, 8'd1};
        present_i = 4'hF;
        do_reset();
        check("R1 reset stage", 32'(stage_o), 0);
        check("R1 reset outputs", 32'({panel_vdd_o, lvds_en_o, bl_vdd_o, bl_en_o,
              pwm_run_o, pwm_load_o, done_o}), 0);
        check("R1 reset duty", 32'(pwm_duty_o), 0);
        pulse_start();
        c1 = cyc;
        check("R3 start runs at once", 32'(stage_o), 1);
        repeat (10) @(negedge clk);
        pulse_start();
        check("R10 start while busy", 32'(stage_o), 1);
        wait_change(c2);
        check("R4 R12 delay0 across wrap", 32'(c2 - c1), 1000);
        check("R8 advance without poll", 32'(stage_o), 2);
        check("R6 panel supply up", 32'(panel_vdd_o), 1);
        wait_change(c3);
        check("R4 zero delay", 32'(c3 - c2), 1);
        wait_change(c4);
        check("R4 delay2", 32'(c4 - c3), 2000);
        wait_change(c5);
        check("R4 delay3", 32'(c5 - c4), 1000);
        check("R9 load strobe", 32'(pwm_load_o), 1);
        check("R9 hz", 32'(pwm_hz_o), 32768);
        check("R9 div", 32'(pwm_div_o), 1);
        wait_change(c6);
        check("R5 no wait after PWM", 32'(c6 - c5), 1);
        check("R9 strobe ends", 32'(pwm_load_o), 0);
        @(negedge clk);
        check("R5 no wait after backlight enable", 32'(stage_o), 6);
        check("R13 done", 32'(done_o), 1);
        pulse_start();
        check("R10 start at done", 32'(stage_o), 6);
        check("R11 rails held", 32'({panel_vdd_o, lvds_en_o, bl_vdd_o, bl_en_o}), 4'hF);

        // Directed polled sequence with two absent rails.
        wait_mode_i = 0; delay_ms_i = {4{8'd1}}; present_i = 4'b0101;
        do_reset();
        pulse_start();
        repeat (500) @(negedge clk);
        poll_i = 1; @(negedge clk); poll_i = 0;
        check("R7 early poll ignored", 32'(stage_o), 1);
        repeat (700) @(negedge clk);
        check("R7 no advance without poll", 32'(stage_o), 1);
        poll_i = 1; @(negedge clk);
        c2 = cyc;
        check("R7 poll after deadline", 32'(stage_o), 2);
        wait_change(c3);
        check("R6 absent link still waits", 32'(c3 - c2), 1000);
        check("R6 absent link low", 32'(lvds_en_o), 0);
        while (stage_o != 3'd6 && cyc < 150000) @(negedge clk);
        poll_i = 0;
        check("R6 absent backlight enable low", 32'(bl_en_o), 0);
        check("R6 present backlight supply high", 32'(bl_vdd_o), 1);

        // Random sequences checked cycle by cycle against the model.
        for (int s = 0; s < 6; s++) begin
            int rate = 1 + ($urandom % 2);
            wait_mode_i = $urandom % 2;
            present_i = 4'($urandom);
            for (int k = 0; k < 4; k++) delay_ms_i[k*8 +: 8] = 8'($urandom % 3);
            do_reset();
            start_i = 1;
            for (int n = 0; n < 30000 && !(m_stage == 3'd6 && n > 50); n++) begin
                @(negedge clk);
                start_i     = ($urandom % 40) == 0;
                poll_i      = ($urandom % 3) == 0;
                usec_tick_i = ($urandom % rate) == 0;
            end
            start_i = 0; poll_i = 0; usec_tick_i = 1;
            check("R8 R7 sequence completes", 32'(done_o), 1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule